// File: doc/BRIEF.md
# Trigger Pulse and Edge Timestamp Unit

The block issues a single trigger pulse of fixed length when a start request arrives. It also runs a cycle counter that restarts from zero whenever a pulse begins. It records the counter value at two kinds of event: the rising edge of its own trigger, and the rising edge of an external detect line whose timing has no relation to the clock. Each recorded value is presented with a strobe that is high for one cycle, so a consumer can read the time of a detect event relative to the trigger it launched.

Everything runs on one clock. The trigger length is given in nanoseconds and converted to clock cycles from the clock frequency parameter. The detect line passes through a synchronizer before its edges are sought. Edges are found by comparing a registered sample with the sample one cycle older, and each edge acts as a capture enable on the free-running counter.

Top module: `trig_stamp_unit`

## Requirements
- R1: While `rst_ni` is low, `trig_o`, both stamp outputs and both valid strobes are 0, and the counter is held at 0.
- R2: A start request sampled at a clock edge while no pulse is running drives `trig_o` high from that edge for exactly PULSE_CYC cycles. PULSE_CYC is the pulse length in ns times the clock frequency, rounded up (50 at 100 MHz and 500 ns).
- R3: A start request sampled while a pulse is running has no effect on that pulse. If the request is held high, the next pulse begins one cycle after the current one ends.
- R4: The counter loads 0 at the edge where a pulse starts. At every other edge it counts up by 1, and it stays at 2^CNT_W-1 instead of wrapping.
- R5: A pulse started at edge k causes `trig_stamp_vld_o` to be high for the one cycle after edge k+2. At that edge `trig_stamp_o` takes the counter value, which is 1.
- R6: Suppose `detect_i` is sampled high at edge a after being sampled low at edge a-1. Then `det_stamp_vld_o` is high for the one cycle after edge a+3, and `det_stamp_o` takes the counter value that was present after edge a+2.
- R7: A falling edge or an unchanging level on `detect_i` produces no detect strobe.
- R8: When both captures happen at the same edge, both stamp outputs hold the same counter value.
- R9: Each stamp output keeps its value at every edge where its own strobe is not raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, the only clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to launch a trigger pulse |
| detect_i | input | 1 | External event line, asynchronous |
| trig_o | output | 1 | Trigger pulse |
| trig_stamp_o | output | CNT_W | Counter value taken at the trigger rising edge |
| trig_stamp_vld_o | output | 1 | One-cycle strobe for trig_stamp_o |
| det_stamp_o | output | CNT_W | Counter value taken at the detect rising edge |
| det_stamp_vld_o | output | 1 | One-cycle strobe for det_stamp_o |

## Verification
The bench makes a detect edge land in the same capture cycle as a trigger edge. A design whose two captures read different counter taps would then report unequal stamps. It holds start high through a whole pulse and beyond, which catches a pulse that gets extended or restarted, and a gap between pulses that is wrong by a cycle. It lets the counter run for far longer than its range before a detect edge arrives, so a counter that wraps gives a small stamp instead of the maximum. Random detect toggling then checks the three-cycle latency and confirms that falling edges never raise a strobe.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
  // Pulse length in cycles, rounded up so the pulse is never shorter than requested.
  function automatic int unsigned ns_to_cycles(longint unsigned clk_hz, int unsigned dur_ns);
    longint unsigned num;
    num = clk_hz * 64'(dur_ns) + 64'd999_999_999;
    return 32'(num / 64'd1_000_000_000);
  endfunction
endpackage

// File: rtl/tsu_pulse_gen.sv
module tsu_pulse_gen #(
  parameter int unsigned PULSE_CYC = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic trig_o,
  output logic launch_o
);
  localparam int unsigned DW = $clog2(PULSE_CYC + 1);

  logic          trig_q;
  logic [DW-1:0] dur_q;

  assign launch_o = start_i & ~trig_q;
  assign trig_o   = trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= 1'b0;
      dur_q  <= '0;
    end else if (launch_o) begin
      trig_q <= 1'b1;
      dur_q  <= DW'(PULSE_CYC - 1);
    end else if (trig_q) begin
      if (dur_q == '0) trig_q <= 1'b0;
      else             dur_q  <= dur_q - 1'b1;
    end
  end

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q && dur_q != '0) |=> trig_q);
  a_r2_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trig_q) |-> $past(start_i));
  a_r3_busy_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q && start_i && dur_q != '0) |=> (trig_q && dur_q == $past(dur_q) - 1'b1));
endmodule

// File: rtl/tsu_timebase.sv
module tsu_timebase #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  a_r4_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !clr_i) |=> cnt_q == CNT_MAX);
  a_r4_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/tsu_edge_det.sv
module tsu_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_s;
  logic new_q, old_q;

  if (SYNC_STAGES > 0) begin : g_sync
    logic [SYNC_STAGES-1:0] sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q <= '0;
      else begin
        sync_q[0] <= lvl_i;
        for (int i = 1; i < int'(SYNC_STAGES); i++) sync_q[i] <= sync_q[i-1];
      end
    end
    assign lvl_s = sync_q[SYNC_STAGES-1];
  end else begin : g_direct
    assign lvl_s = lvl_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      new_q <= 1'b0;
      old_q <= 1'b0;
    end else begin
      new_q <= lvl_s;
      old_q <= new_q;
    end
  end

  assign rise_o = new_q & ~old_q;

  a_r7_no_repeat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tsu_stamp_reg.sv
module tsu_stamp_reg #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] val_o,
  output logic             vld_o
);
  logic [CNT_W-1:0] val_q;
  logic             vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= cap_i;
      if (cap_i) val_q <= cnt_i;
    end
  end

  assign val_o = val_q;
  assign vld_o = vld_q;

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_q |-> $stable(val_q));
endmodule

// File: rtl/trig_stamp_unit.sv
module trig_stamp_unit #(
  parameter longint unsigned CLK_HZ      = 64'd100_000_000,
  parameter int unsigned     PULSE_NS    = 500,
  parameter int unsigned     CNT_W       = 16,
  parameter int unsigned     SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             detect_i,
  output logic             trig_o,
  output logic [CNT_W-1:0] trig_stamp_o,
  output logic             trig_stamp_vld_o,
  output logic [CNT_W-1:0] det_stamp_o,
  output logic             det_stamp_vld_o
);
  localparam int unsigned PULSE_CYC = tsu_pkg::ns_to_cycles(CLK_HZ, PULSE_NS);

  logic             launch;
  logic [CNT_W-1:0] cnt;
  logic             trig_rise, det_rise;

  tsu_pulse_gen #(.PULSE_CYC(PULSE_CYC)) i_pulse (
    .clk_i, .rst_ni, .start_i, .trig_o, .launch_o(launch)
  );

  tsu_timebase #(.CNT_W(CNT_W)) i_timebase (
    .clk_i, .rst_ni, .clr_i(launch), .cnt_o(cnt)
  );

  // Trigger is already synchronous: edge pair only.
  tsu_edge_det #(.SYNC_STAGES(0)) i_trig_edge (
    .clk_i, .rst_ni, .lvl_i(trig_o), .rise_o(trig_rise)
  );

  tsu_edge_det #(.SYNC_STAGES(SYNC_STAGES)) i_det_edge (
    .clk_i, .rst_ni, .lvl_i(detect_i), .rise_o(det_rise)
  );

  tsu_stamp_reg #(.CNT_W(CNT_W)) i_trig_stamp (
    .clk_i, .rst_ni, .cap_i(trig_rise), .cnt_i(cnt),
    .val_o(trig_stamp_o), .vld_o(trig_stamp_vld_o)
  );

  tsu_stamp_reg #(.CNT_W(CNT_W)) i_det_stamp (
    .clk_i, .rst_ni, .cap_i(det_rise), .cnt_i(cnt),
    .val_o(det_stamp_o), .vld_o(det_stamp_vld_o)
  );

  a_r8_same_stamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_stamp_vld_o && det_stamp_vld_o) |-> trig_stamp_o == det_stamp_o);
  a_r5_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_stamp_vld_o |=> !trig_stamp_vld_o);
  a_r6_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_stamp_vld_o |=> !det_stamp_vld_o);
endmodule

// File: tb/test_trig_stamp_unit.sv
module test_trig_stamp_unit;
  localparam int CNT_W = 10;
  localparam int MAXV  = (1 << CNT_W) - 1;
  localparam int PULSE = 50;

  logic clk = 1'b0;
  logic rst_n;
  logic start_r, det_r;
  logic trig_o, tv_o, dv_o;
  logic [CNT_W-1:0] tval_o, dval_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  trig_stamp_unit #(.CNT_W(CNT_W)) i_trig_stamp_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_r), .detect_i(det_r),
    .trig_o(trig_o), .trig_stamp_o(tval_o), .trig_stamp_vld_o(tv_o),
    .det_stamp_o(dval_o), .det_stamp_vld_o(dv_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Expected behaviour, advanced at each edge from the requirements.
  int   m_left, m_cnt, m_tval, m_dval;
  bit   m_tv, m_dv;
  bit [1:0] m_th;
  bit [3:0] m_dh;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_left = 0; m_cnt = 0; m_tval = 0; m_dval = 0;
      m_tv = 0; m_dv = 0; m_th = '0; m_dh = '0;
    end else begin
      bit acc, lvl;
      acc  = (m_left == 0) && start_r;
      lvl  = (m_left > 0);
      m_tv = m_th[0] && !m_th[1];            // R5: edge k+2
      m_dv = m_dh[2] && !m_dh[3];            // R6: edge a+3
      if (m_tv) m_tval = m_cnt;
      if (m_dv) m_dval = m_cnt;
      m_th = {m_th[0], lvl};
      m_dh = {m_dh[2:0], det_r};
      m_cnt  = acc ? 0 : (m_cnt == MAXV ? MAXV : m_cnt + 1);
      m_left = acc ? PULSE : (m_left > 0 ? m_left - 1 : 0);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk((start_r && m_left > 0) ? "R3" : "R2", "trig_o", int'(trig_o), int'(m_left > 0));
      chk("R5", "trig_vld", int'(tv_o), int'(m_tv));
      chk(m_dv ? "R6" : "R7", "det_vld", int'(dv_o), int'(m_dv));
      chk(m_tv ? "R5" : "R9", "trig_stamp", int'(tval_o), m_tval);
      chk(!m_dv ? "R9" : (m_dval == MAXV ? "R4" : "R6"), "det_stamp", int'(dval_o), m_dval);
      if (m_tv && m_dv) chk("R8", "stamps_equal", int'(dval_o), int'(tval_o));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start_r = 1'b0; det_r = 1'b0;
    cyc(3);
    // R1
    chk("R1", "trig_o", int'(trig_o), 0);
    chk("R1", "trig_vld", int'(tv_o), 0);
    chk("R1", "det_vld", int'(dv_o), 0);
    chk("R1", "trig_stamp", int'(tval_o), 0);
    chk("R1", "det_stamp", int'(dval_o), 0);
    rst_n = 1'b1;
    cyc(5);

    // R8: detect edge one cycle ahead of the start sample lands on the same capture edge
    det_r = 1'b1; cyc(1);
    start_r = 1'b1; cyc(1);
    start_r = 1'b0; cyc(8);
    // R3: start during pulse
    start_r = 1'b1; cyc(5);
    start_r = 1'b0; det_r = 1'b0; cyc(6);
    det_r = 1'b1; cyc(60);

    // R3: start held across two pulses
    start_r = 1'b1; cyc(120);
    start_r = 1'b0; cyc(60);

    // R4: counter saturates
    det_r = 1'b0;
    start_r = 1'b1; cyc(1);
    start_r = 1'b0; cyc(1100);
    det_r = 1'b1; cyc(10);

    // random mix
    for (int i = 0; i < 6000; i++) begin
      start_r = ($urandom_range(59) == 0);
      if ($urandom_range(4) == 0) det_r = ~det_r;
      cyc(1);
    end
    start_r = 1'b0; cyc(10);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule